// File: doc/BRIEF.md
# Shared Interrupt Source Conditioner

This block sits between a bank of external interrupt lines and the logic that routes interrupts to processors. Each input line is first brought into the clock domain through a two-stage synchroniser. It is then qualified by a per-source polarity bit and a per-source trigger mode: level, single edge, or both edges. Edge events are caught in a per-source latch, and the resulting pending state is gated by a per-source enable. The gated result goes out on a registered vector.

Software programs the block over a simple 32-bit register bus. Every per-source setting is packed 32 sources to a word. Enables are never written directly: one bank sets enables and another clears them, and a read-only bank reports the current enables. A single edge-control register lets software set or clear any one edge latch by source number. A read-only pending bank reports the conditioned state of every source.

Top module: `intsrc_cond`

## Requirements
- R1: After reset, the polarity, trigger, dual-edge and enable state is all zero, every edge latch is clear and `irq_out` is zero.
- R2: Banks are selected by `bus_addr[9:7]`: polarity 0x000, trigger 0x080, dual-edge 0x100, enable-set 0x180, enable-clear 0x200, enable-status 0x280, pending 0x300, edge-control 0x380. Source n sits in the word at (n/32)*4 within a bank, at bit n%32. The polarity, trigger and dual-edge banks read back what was written.
- R3: A source whose trigger bit is 0 (level) reads as pending while its synchronised input equals its polarity bit: 1 means active high and 0 means active low.
- R4: A source whose trigger bit is 1 (edge) and whose dual-edge bit is 0 latches on a rising transition when its polarity is 1, and on a falling transition when its polarity is 0. It stays pending after the input returns, until software clears it.
- R5: An edge source with its dual-edge bit set latches on both rising and falling transitions.
- R6: Writing to the enable-set bank turns on the sources whose data bits are 1. Writing to the enable-clear bank turns off the sources whose data bits are 1. Data bits of 0 leave enables unchanged, and both banks read as zero.
- R7: The enable-status bank is read-only and reports 1 for each enabled source. The pending bank is read-only and reports the conditioned pending state.
- R8: A write to the edge-control register (word 0 only) names a source in data bits 7:0. Bit 31 = 1 sets that source's edge latch and bit 31 = 0 clears it. A number at or above the source count has no effect, and the latches of level-mode sources are held at 0.
- R9: If a hardware edge and a software clear of the same latch fall in one cycle, the latch ends up set.
- R10: `irq_out` is the pending vector ANDed with the enables, registered one cycle later.
- R11: `bus_rdata` is loaded one cycle after a read and holds its value while no read is made. An access whose `bus_addr[1:0]` is not zero reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_SRC | Enabled pending sources, registered |

## Verification
Two functions can land in the same cycle: the hardware edge detector setting a latch, and a software clear of that same latch through the edge-control register. The bench provokes this by timing the clear write so that it is sampled on exactly the edge where the synchronised transition is first seen. It expects the pending bit to survive. A control case issues the same clear one cycle later and expects the bit to drop. Random configuration and input patterns are then checked against a bench model of pending, enables and `irq_out`.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 10;
  localparam int NUM_FLD_W  = 8;
  localparam int OP_BIT     = 31;

  typedef enum logic [2:0] {
    BK_POL   = 3'd0,
    BK_TRIG  = 3'd1,
    BK_DUAL  = 3'd2,
    BK_ENSET = 3'd3,
    BK_ENCLR = 3'd4,
    BK_ENSTA = 3'd5,
    BK_PEND  = 3'd6,
    BK_EDGE  = 3'd7
  } bank_e;
endpackage

// File: rtl/intsrc_sync.sv
module intsrc_sync #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      stage1 <= async_in;
      cur    <= stage1;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/intsrc_cell.sv
module intsrc_cell (
  input  logic clk,
  input  logic rst,
  input  logic cur,
  input  logic prev,
  input  logic pol,
  input  logic trig,
  input  logic dual,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pending,
  output logic latch_q
);
  logic rise, fall, hit, level_act, latch_d;

  always_comb begin
    rise      = cur & ~prev;
    fall      = ~cur & prev;
    level_act = pol ? cur : ~cur;
    hit       = trig & (dual ? (rise | fall) : (pol ? rise : fall));
    latch_d   = trig & (hit | sw_set | (latch_q & ~sw_clr));
    pending   = trig ? latch_q : level_act;
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= 1'b0;
    else     latch_q <= latch_d;
  end
endmodule

// File: rtl/intsrc_regs.sv
module intsrc_regs
  import intsrc_pkg::*;
#(
  parameter int N = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [N-1:0]      pend,
  output logic [REG_W-1:0]  rdata,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      trig_q,
  output logic [N-1:0]      dual_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      sw_set,
  output logic [N-1:0]      sw_clr
);
  logic       aligned;
  bank_e      bank;
  logic [4:0] widx;
  logic       edge_wr;
  logic [REG_W-1:0] rd_word;

  assign aligned = (addr[1:0] == 2'b00);
  assign bank    = bank_e'(addr[9:7]);
  assign widx    = addr[6:2];
  assign edge_wr = wr && aligned && (bank == BK_EDGE) && (widx == 5'd0);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      sw_set[i] = edge_wr &&  wdata[OP_BIT] && (wdata[NUM_FLD_W-1:0] == NUM_FLD_W'(i));
      sw_clr[i] = edge_wr && !wdata[OP_BIT] && (wdata[NUM_FLD_W-1:0] == NUM_FLD_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '0;
      trig_q <= '0;
      dual_q <= '0;
      en_q   <= '0;
    end else if (wr && aligned) begin
      for (int i = 0; i < N; i++) begin
        if (widx == 5'(i / REG_W)) begin
          case (bank)
            BK_POL:   pol_q[i]  <= wdata[i % REG_W];
            BK_TRIG:  trig_q[i] <= wdata[i % REG_W];
            BK_DUAL:  dual_q[i] <= wdata[i % REG_W];
            BK_ENSET: if (wdata[i % REG_W]) en_q[i] <= 1'b1;
            BK_ENCLR: if (wdata[i % REG_W]) en_q[i] <= 1'b0;
            default:  ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      for (int i = 0; i < N; i++) begin
        if (widx == 5'(i / REG_W)) begin
          case (bank)
            BK_POL:   rd_word[i % REG_W] = pol_q[i];
            BK_TRIG:  rd_word[i % REG_W] = trig_q[i];
            BK_DUAL:  rd_word[i % REG_W] = dual_q[i];
            BK_ENSTA: rd_word[i % REG_W] = en_q[i];
            BK_PEND:  rd_word[i % REG_W] = pend[i];
            default:  ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_word;
  end
endmodule

// File: rtl/intsrc_cond.sv
module intsrc_cond
  import intsrc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [9:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_SRC-1:0] irq_out
);
  logic [NUM_SRC-1:0] s_cur, s_prev;
  logic [NUM_SRC-1:0] pol_q, trig_q, dual_q, en_q;
  logic [NUM_SRC-1:0] sw_set, sw_clr;
  logic [NUM_SRC-1:0] pend_vec, latch_vec;

  intsrc_sync #(.N(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .async_in(src_in), .cur(s_cur), .prev(s_prev)
  );

  intsrc_regs #(.N(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .pend(pend_vec), .rdata(bus_rdata),
    .pol_q(pol_q), .trig_q(trig_q), .dual_q(dual_q), .en_q(en_q),
    .sw_set(sw_set), .sw_clr(sw_clr)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    intsrc_cell u_cell (
      .clk(clk), .rst(rst), .cur(s_cur[g]), .prev(s_prev[g]),
      .pol(pol_q[g]), .trig(trig_q[g]), .dual(dual_q[g]),
      .sw_set(sw_set[g]), .sw_clr(sw_clr[g]),
      .pending(pend_vec[g]), .latch_q(latch_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= pend_vec & en_q;
  end
endmodule

// File: rtl/intsrc_cond_chk.sv
module intsrc_cond_chk #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [31:0]        bus_rdata,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] trig_q,
  input logic [NUM_SRC-1:0] latch_vec,
  input logic [NUM_SRC-1:0] irq_out
);
  // R10: nothing leaves on irq_out unless it was enabled the cycle before
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_out & ~$past(en_q)) == '0));

  // R6: enables move only on a bus write
  assert_en_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> (en_q == $past(en_q)));

  // R8: a level-mode source never carries a set edge latch
  assert_level_no_latch_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_vec & ~$past(trig_q)) == '0));

  // R11: read data holds without a read strobe
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind intsrc_cond intsrc_cond_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .en_q(en_q), .trig_q(trig_q),
  .latch_vec(latch_vec), .irq_out(irq_out)
);

// File: tb/tb_intsrc_cond.sv
module tb_intsrc_cond;
  localparam int N = 64;
  localparam int W = 2;
  localparam logic [9:0] A_POL = 10'h000, A_TRIG = 10'h080, A_DUAL = 10'h100,
    A_SET = 10'h180, A_CLR = 10'h200, A_STA = 10'h280, A_PEND = 10'h300, A_EDGE = 10'h380;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src_in = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_out;

  int tests = 0, fails = 0;
  logic [N-1:0] m_pol = '0, m_trig = '0, m_dual = '0, m_en = '0, m_latch = '0, m_in = '0;

  always #2.5 clk = ~clk;

  intsrc_cond #(.NUM_SRC(N)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_pend();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++)
      p[i] = m_trig[i] ? m_latch[i] : (m_pol[i] ? m_in[i] : ~m_in[i]);
    return p;
  endfunction

  function automatic logic [31:0] word_of(logic [N-1:0] v, int w);
    return v[w*32 +: 32];
  endfunction

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // configuration write plus model update
  task automatic cfg(logic [9:0] base, int w, logic [31:0] d);
    wr(base + 10'(w * 4), d);
    for (int b = 0; b < 32; b++) begin
      case (base)
        A_POL:  m_pol[w*32+b] = d[b];
        A_TRIG: m_trig[w*32+b] = d[b];
        A_DUAL: m_dual[w*32+b] = d[b];
        A_SET:  if (d[b]) m_en[w*32+b] = 1'b1;
        A_CLR:  if (d[b]) m_en[w*32+b] = 1'b0;
        default: ;
      endcase
    end
    m_latch &= m_trig;
  endtask

  task automatic edge_op(int num, logic set);
    wr(A_EDGE, {set, 23'd0, 8'(num)});
    if (num < N && m_trig[num]) m_latch[num] = set;
  endtask

  task automatic drive_in(logic [N-1:0] v);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      logic r, f;
      r = v[i] & ~m_in[i];
      f = ~v[i] & m_in[i];
      if (m_trig[i] && (m_dual[i] ? (r | f) : (m_pol[i] ? r : f))) m_latch[i] = 1'b1;
    end
    src_in = v; m_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    for (int w = 0; w < W; w++) begin
      rd(A_PEND + 10'(w * 4), d);
      chk({req, " pending"}, 64'(d), 64'(word_of(exp_pend(), w)));
      rd(A_STA + 10'(w * 4), d);
      chk({req, " enable status"}, 64'(d), 64'(word_of(m_en, w)));
    end
    @(negedge clk);
    chk({req, " irq_out"}, 64'(irq_out), 64'(exp_pend() & m_en));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, hold;
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq_out", 64'(irq_out), 64'd0);
    for (int w = 0; w < W; w++) begin
      rd(A_POL + 10'(w*4), d);  chk("R1 polarity", 64'(d), 64'd0);
      rd(A_TRIG + 10'(w*4), d); chk("R1 trigger", 64'(d), 64'd0);
      rd(A_DUAL + 10'(w*4), d); chk("R1 dual", 64'(d), 64'd0);
      rd(A_STA + 10'(w*4), d);  chk("R1 enable", 64'(d), 64'd0);
      rd(A_PEND + 10'(w*4), d); chk("R3 low-active level at reset", 64'(d), 64'hFFFF_FFFF);
    end

    // R2 layout and readback
    cfg(A_POL, 1, 32'hA5C3_0F01);
    rd(A_POL + 10'd4, d); chk("R2 polarity word1", 64'(d), 64'hA5C3_0F01);
    rd(A_POL, d);         chk("R2 polarity word0 untouched", 64'(d), 64'd0);
    cfg(A_DUAL, 0, 32'h0000_8001);
    rd(A_DUAL, d);        chk("R2 dual word0", 64'(d), 64'h0000_8001);
    cfg(A_POL, 1, 32'd0); cfg(A_DUAL, 0, 32'd0);

    // R3 level
    cfg(A_POL, 0, 32'hFFFF_0000);
    drive_in(64'h0000_0000_00FF_00FF);
    check_all("R3 level");

    // R6 / R7 enables
    cfg(A_SET, 0, 32'h0F0F_00F0);
    cfg(A_SET, 0, 32'h0000_0001);
    cfg(A_CLR, 0, 32'h0000_0F00);
    cfg(A_SET, 1, 32'h8000_0001);
    rd(A_SET, d); chk("R6 set bank reads zero", 64'(d), 64'd0);
    rd(A_CLR, d); chk("R6 clear bank reads zero", 64'(d), 64'd0);
    rd(A_STA, d); chk("R7 enable status word0", 64'(d), 64'h0F0F_00F1);
    check_all("R10 masked output");

    // R4 single edge, polarity 1 on source 5
    cfg(A_POL, 0, 32'h0000_0020); cfg(A_TRIG, 0, 32'h0000_0020);
    cfg(A_SET, 0, 32'h0000_0020);
    drive_in(m_in & ~64'h20);
    edge_op(5, 1'b0);
    drive_in(m_in | 64'h20);
    rd(A_PEND, d); chk("R4 rising latched", 64'(d[5]), 64'd1);
    drive_in(m_in & ~64'h20);
    rd(A_PEND, d); chk("R4 held after return", 64'(d[5]), 64'd1);
    edge_op(5, 1'b0);
    rd(A_PEND, d); chk("R8 software clear", 64'(d[5]), 64'd0);
    // polarity 0: falling only
    cfg(A_POL, 0, 32'h0);
    drive_in(m_in | 64'h20);
    rd(A_PEND, d); chk("R4 rise ignored for polarity 0", 64'(d[5]), 64'd0);
    drive_in(m_in & ~64'h20);
    rd(A_PEND, d); chk("R4 falling latched", 64'(d[5]), 64'd1);

    // R5 dual edge on source 40
    cfg(A_TRIG, 1, 32'h0000_0100); cfg(A_DUAL, 1, 32'h0000_0100);
    edge_op(40, 1'b0);
    drive_in(m_in | (64'd1 << 40));
    rd(A_PEND + 10'd4, d); chk("R5 dual rising", 64'(d[8]), 64'd1);
    edge_op(40, 1'b0);
    drive_in(m_in & ~(64'd1 << 40));
    rd(A_PEND + 10'd4, d); chk("R5 dual falling", 64'(d[8]), 64'd1);

    // R8 injection paths
    edge_op(40, 1'b0);
    edge_op(40, 1'b1);
    rd(A_PEND + 10'd4, d); chk("R8 software set", 64'(d[8]), 64'd1);
    edge_op(64, 1'b0);
    check_all("R8 out-of-range number ignored");
    edge_op(3, 1'b1);
    check_all("R8 level source ignores set");

    // R9 collision: hardware edge and software clear same cycle, source 10
    cfg(A_POL, 0, m_pol[31:0] | 32'h400); cfg(A_TRIG, 0, m_trig[31:0] | 32'h400);
    cfg(A_DUAL, 0, m_dual[31:0] & ~32'h400);
    drive_in(m_in & ~64'h400);
    edge_op(10, 1'b0);
    @(negedge clk); src_in[10] = 1'b1; m_in[10] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(A_EDGE, {1'b0, 23'd0, 8'd10});
    m_latch[10] = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_PEND, d); chk("R9 edge wins over clear", 64'(d[10]), 64'd1);
    drive_in(m_in & ~64'h400);
    edge_op(10, 1'b0);
    @(negedge clk); src_in[10] = 1'b1; m_in[10] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    wr(A_EDGE, {1'b0, 23'd0, 8'd10});
    m_latch[10] = 1'b0;
    repeat (3) @(negedge clk);
    rd(A_PEND, d); chk("R9 later clear drops latch", 64'(d[10]), 64'd0);

    // R11 unaligned access and hold
    wr(A_POL + 10'd1, 32'hFFFF_FFFF);
    rd(A_POL, d); chk("R11 unaligned write ignored", 64'(d), 64'(m_pol[31:0]));
    rd(A_STA + 10'd2, d); chk("R11 unaligned read zero", 64'(d), 64'd0);
    rd(A_STA, hold);
    repeat (5) @(negedge clk);
    chk("R11 rdata held", 64'(bus_rdata), 64'(hold));

    // random phase
    for (int it = 0; it < 40; it++) begin
      int w, sel;
      w = int'($urandom % W);
      sel = int'($urandom % 5);
      case (sel)
        0: cfg(A_POL, w, $urandom);
        1: cfg(A_TRIG, w, $urandom);
        2: cfg(A_DUAL, w, $urandom);
        3: cfg(A_SET, w, $urandom);
        default: cfg(A_CLR, w, $urandom);
      endcase
      drive_in({$urandom, $urandom});
      if ($urandom % 2) edge_op(int'($urandom % 72), 1'($urandom));
      check_all("R3 R4 R5 R10 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule